// File: doc/BRIEF.md
# Isolated Open-Drain Bus Repeater Side

This block is a digital model of one half of a bidirectional repeater for an open-drain line, such as the clock or data wire of an I2C bus, split by an isolation link. Each half has a local bus port (a sampled bus level and a pull-low output) and a link port (one bit sent toward the far half, one bit received from it). The link latency lives outside the block. Two instances, one of each variant, joined through delay lines, form a complete repeater.

The variant is chosen with the `KIND` parameter. The holding side (`SIDE_HOLD`) sees the local bus through a comparator that ignores its own limited-level low. It qualifies external lows with a synchronizer and a symmetric glitch filter, and forwards them. A short local pulse is latched in a hold flag that keeps the local bus low until the far side's echo comes back. That prevents extra or missing edges on either side. The echo side (`SIDE_ECHO`) sees the full wired bus level, including its own drive. It therefore returns every assertion it receives, and it drives its bus from the received bit alone.

All pins are single-bit levels with no transfer semantics. There is no valid/ready handshake and no back-pressure: a level on the link is a state, not a token, and it is never lost or queued. `link_tx`/`link_rx` high means "low is asserted". `drive_low` high means "pull the bus low". `bus_in` is 1 when the sampled bus is high.

Top module: `odr_side`

## Requirements
- R1: While `rst_n` is low, `link_tx` and `drive_low` are 0. After reset, the hold flag is clear and the filtered level reads "released".
- R2: The filtered local level changes only after FILT_LEN consecutive synchronized samples that disagree with it. With SYNC_STAGES=2, `link_tx` rises at the (SYNC_STAGES+FILT_LEN)-th rising edge that samples `bus_in` low. A low or high excursion shorter than FILT_LEN samples has no effect on `link_tx`.
- R3: Holding side: when a local low is accepted, the hold flag sets on the next edge. `drive_low` is 1 while the filtered low or the hold flag is set.
- R4: Holding side: the hold flag clears on the edge after a cycle in which `link_rx` is 1. From then on, `link_rx` alone keeps `drive_low` at 1.
- R5: Holding side: a low that comes only from its own `drive_low` (the far side asserting) never raises `link_tx`.
- R6: Holding side: `link_tx` is the filtered local low OR the hold flag. When the external driver has released and the echo is the only low, `link_tx` falls while `drive_low` is still 1.
- R7: `drive_low` falls only in a cycle where `link_rx` is 0 and the hold flag is clear.
- R8: A local low still present when the echo returns is released by the filter: `link_tx` falls SYNC_STAGES+FILT_LEN edges after `bus_in` returns high.
- R9: A single qualified local pulse on the holding side yields exactly one low pulse on each side's wired bus. A short pulse is stretched to at least four link delays on the holding side and at least two on the echo side.
- R10: Echo side: `link_tx` follows the filtered wired bus level, including a low that comes only from its own drive. `drive_low` equals `link_rx` outside reset.
- R11: When both sides assert overlapping pulses, every `link_tx` and `drive_low` returns to 0 once both external drivers release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 1 | Sampled local bus level, 1 = high |
| drive_low | output | 1 | 1 = pull the local bus low |
| link_tx | output | 1 | 1 = assertion sent to the far side |
| link_rx | input | 1 | 1 = assertion received from the far side |

## Verification
The bench pairs both variants through delay lines and targets short pulses that end before the echo returns. A design that cleared the hold flag early, or never set it, would split the holding-side pulse in two or drop it. The bench also drives long pulses, glitches and high blips just under the filter length. A filter off by one would forward them or delay the release. Pulses that start on the echo side test whether the holding side accepts its own low, which would lock both sides low. Overlapping pulses from both sides must all settle back to released.

// File: rtl/odr_pkg.sv
package odr_pkg;
  typedef enum logic {
    SIDE_ECHO = 1'b0,
    SIDE_HOLD = 1'b1
  } side_kind_e;
endpackage

// File: rtl/odr_sync.sv
module odr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/odr_glitch_filter.sv
module odr_glitch_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic low_q
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [CW-1:0] run_q;
  logic          disagree;

  assign disagree = (~lvl_in) != low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= 1'b0;
      run_q <= '0;
    end else if (disagree) begin
      if (run_q == CW'(FILT_LEN - 1)) begin
        low_q <= ~low_q;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end
endmodule

// File: rtl/odr_link_ctrl.sv
module odr_link_ctrl
  import odr_pkg::*;
#(
  parameter side_kind_e KIND = SIDE_HOLD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loc_low,
  input  logic link_rx,
  output logic link_tx,
  output logic drive_low,
  output logic hold_o
);
  logic prev_q;
  logic hold_q;
  logic accept;

  assign accept = loc_low & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      prev_q <= loc_low;
      if (KIND == SIDE_HOLD) hold_q <= link_rx ? 1'b0 : (hold_q | accept);
      else                   hold_q <= 1'b0;
    end
  end

  generate
    if (KIND == SIDE_HOLD) begin : g_hold
      assign link_tx   = loc_low | hold_q;
      assign drive_low = rst_n & (loc_low | hold_q | link_rx);
    end else begin : g_echo
      assign link_tx   = loc_low;
      assign drive_low = rst_n & link_rx;
    end
  endgenerate

  assign hold_o = hold_q;
endmodule

// File: rtl/odr_side.sv
module odr_side
  import odr_pkg::*;
#(
  parameter side_kind_e KIND        = SIDE_HOLD,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_in,
  output logic drive_low,
  output logic link_tx,
  input  logic link_rx
);
  logic bus_sync;
  logic loc_low;
  logic hold_flag;

  odr_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (bus_in),
    .q     (bus_sync)
  );

  odr_glitch_filter #(
    .FILT_LEN (FILT_LEN)
  ) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_in (bus_sync),
    .low_q  (loc_low)
  );

  odr_link_ctrl #(
    .KIND (KIND)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .loc_low   (loc_low),
    .link_rx   (link_rx),
    .link_tx   (link_tx),
    .drive_low (drive_low),
    .hold_o    (hold_flag)
  );
endmodule

// File: rtl/odr_side_chk.sv
module odr_side_chk
  import odr_pkg::*;
#(
  parameter side_kind_e KIND = SIDE_HOLD
) (
  input logic clk,
  input logic rst_n,
  input logic bus_sync,
  input logic loc_low,
  input logic hold_flag,
  input logic link_rx,
  input logic link_tx,
  input logic drive_low
);
  // R1: outputs quiet the edge after reset is seen
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!link_tx && !drive_low));

  // R2: filtered low only rises after low samples
  a_r2_filter_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loc_low) |-> !$past(bus_sync));

  // R8: filtered low only falls after high samples
  a_r8_filter_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loc_low) |-> $past(bus_sync));

  // R3: hold flag keeps the bus low
  a_r3_hold_drives: assert property (@(posedge clk) disable iff (!rst_n)
    hold_flag |-> drive_low);

  // R4: echo arrival clears the hold flag
  a_r4_rx_clears_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (KIND == SIDE_HOLD && link_rx) |=> !hold_flag);

  // R5: an assertion toward the link starts only from a local qualified low
  a_r5_tx_from_local: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_tx) |-> $rose(loc_low));

  // R7: release only with no echo and no hold
  a_r7_release_rules: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_low) |-> (!link_rx && !hold_flag));
endmodule

bind odr_side odr_side_chk #(.KIND(KIND)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sync  (bus_sync),
  .loc_low   (loc_low),
  .hold_flag (hold_flag),
  .link_rx   (link_rx),
  .link_tx   (link_tx),
  .drive_low (drive_low)
);

// File: tb/tb_odr_side.sv
module tb_odr_side;
  import odr_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int FILT = 4;
  localparam int DLY  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic ext_a = 1'b0, ext_b = 1'b0;
  logic rx_a = 1'b0, rx_b = 1'b0;
  logic tx_a, tx_b, drv_a, drv_b;
  logic bus_a, bus_b;
  assign bus_a = ~(ext_a | drv_a);  // echo side sees its own low
  assign bus_b = ~ext_b;            // holding side comparator ignores own limited low

  odr_side #(.KIND(SIDE_HOLD), .SYNC_STAGES(SYNC), .FILT_LEN(FILT)) dut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_b), .drive_low(drv_b),
    .link_tx(tx_b), .link_rx(rx_b));

  odr_side #(.KIND(SIDE_ECHO), .SYNC_STAGES(SYNC), .FILT_LEN(FILT)) u_far (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_a), .drive_low(drv_a),
    .link_tx(tx_a), .link_rx(rx_a));

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model state: index 0 = echo side, 1 = holding side
  int m_s1[2] = '{1, 1};
  int m_s2[2] = '{1, 1};
  int m_flt[2] = '{0, 0};
  int m_run[2] = '{0, 0};
  int m_prev = 0, m_hold = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_s1[k] = 1; m_s2[k] = 1; m_flt[k] = 0; m_run[k] = 0;
      end
      m_prev = 0; m_hold = 0;
    end else begin
      m_hold = rx_b ? 0 : ((m_hold != 0 || (m_flt[1] != 0 && m_prev == 0)) ? 1 : 0);
      m_prev = m_flt[1];
      for (int k = 0; k < 2; k++) begin
        int samp;
        samp = m_s2[k];
        m_s2[k] = m_s1[k];
        m_s1[k] = (k == 0) ? int'(bus_a) : int'(bus_b);
        if ((samp == 0) != (m_flt[k] != 0)) begin
          m_run[k]++;
          if (m_run[k] == FILT) begin
            m_flt[k] = 1 - m_flt[k];
            m_run[k] = 0;
          end
        end else begin
          m_run[k] = 0;
        end
      end
    end
  end

  // link delay lines, monitors and per-cycle comparison
  logic [DLY-1:0] dl_ab = '0, dl_ba = '0;
  int pulses_a, pulses_b, run_a, run_b, width_a, width_b;
  int lat_b;
  bit prev_wa, prev_wb, prev_txb, tx_b_seen;
  bit seen_hold_only, seen_echo_drop, seen_a_own, seen_txb_any;

  task automatic clear_mon();
    pulses_a = 0; pulses_b = 0; run_a = 0; run_b = 0; width_a = 0; width_b = 0;
    lat_b = 0; tx_b_seen = 0;
    seen_hold_only = 0; seen_echo_drop = 0; seen_a_own = 0; seen_txb_any = 0;
  endtask

  always @(negedge clk) begin
    int e_txb, e_drvb, e_drva;
    bit wa, wb;
    e_txb  = (m_flt[1] != 0 || m_hold != 0) ? 1 : 0;
    e_drvb = (rst_n && (m_flt[1] != 0 || m_hold != 0 || rx_b)) ? 1 : 0;
    e_drva = (rst_n && rx_a) ? 1 : 0;
    if (int'(tx_a) != m_flt[0]) check(0, "R10", "tx_a per-cycle", int'(tx_a), m_flt[0]);
    if (int'(drv_a) != e_drva)  check(0, "R10", "drv_a per-cycle", int'(drv_a), e_drva);
    if (int'(tx_b) != e_txb)    check(0, "R6", "tx_b per-cycle", int'(tx_b), e_txb);
    if (int'(drv_b) != e_drvb)  check(0, "R3", "drv_b per-cycle", int'(drv_b), e_drvb);

    wa = ext_a | drv_a;
    wb = ext_b | drv_b;
    if (wa && !prev_wa) pulses_a++;
    if (wb && !prev_wb) pulses_b++;
    if (wa) run_a++; else if (prev_wa) begin width_a = run_a; run_a = 0; end
    if (wb) run_b++; else if (prev_wb) begin width_b = run_b; run_b = 0; end
    if (ext_b && !tx_b && !tx_b_seen) lat_b++;
    if (tx_b) begin tx_b_seen = 1; seen_txb_any = 1; end
    if (drv_b && !ext_b && !rx_b) seen_hold_only = 1;
    if (prev_txb && !tx_b && drv_b) seen_echo_drop = 1;
    if (tx_a && !ext_a) seen_a_own = 1;
    prev_wa = wa; prev_wb = wb; prev_txb = tx_b;

    if (!rst_n) begin
      dl_ab = '0; dl_ba = '0;
    end else begin
      dl_ab = {dl_ab[DLY-2:0], tx_a};
      dl_ba = {dl_ba[DLY-2:0], tx_b};
    end
    rx_b = dl_ab[DLY-1];
    rx_a = dl_ba[DLY-1];
  end

  task automatic pulse_b(input int n);
    @(posedge clk); #1 ext_b = 1'b1;
    repeat (n) @(posedge clk);
    #1 ext_b = 1'b0;
  endtask

  task automatic pulse_a(input int n);
    @(posedge clk); #1 ext_a = 1'b1;
    repeat (n) @(posedge clk);
    #1 ext_a = 1'b0;
  endtask

  task automatic settle();
    repeat (150) @(posedge clk);
    @(negedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    #1;
    check(tx_b == 1'b0, "R1", "tx_b in reset", int'(tx_b), 0);
    check(drv_b == 1'b0, "R1", "drv_b in reset", int'(drv_b), 0);
    check(tx_a == 1'b0, "R1", "tx_a in reset", int'(tx_a), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // short holding-side pulse: stretched by hold flag until the echo returns
    clear_mon();
    pulse_b(FILT + 2);
    settle();
    check(lat_b == SYNC + FILT, "R2", "assert latency", lat_b, SYNC + FILT);
    check(pulses_a == 1, "R9", "short: echo-side pulses", pulses_a, 1);
    check(pulses_b == 1, "R9", "short: hold-side pulses", pulses_b, 1);
    check(width_b >= 4 * DLY, "R9", "short: hold-side width", width_b, 4 * DLY);
    check(width_a >= 2 * DLY, "R9", "short: echo-side width", width_a, 2 * DLY);
    check(seen_hold_only, "R3", "hold flag drove bus alone", int'(seen_hold_only), 1);
    check(seen_echo_drop, "R6", "tx drop under echo only", int'(seen_echo_drop), 1);
    check(seen_a_own, "R10", "echo side returned own low", int'(seen_a_own), 1);
    check(!drv_a && !drv_b, "R7", "short: all released", int'(drv_a | drv_b), 0);

    // long pulse: echo returns before release; filter forwards the release
    clear_mon();
    pulse_b(60);
    settle();
    check(pulses_a == 1, "R8", "long: echo-side pulses", pulses_a, 1);
    check(pulses_b == 1, "R4", "long: hold-side pulses", pulses_b, 1);
    check(width_a >= 55, "R8", "long: echo-side width", width_a, 55);

    // glitch shorter than the filter
    clear_mon();
    pulse_b(FILT - 1);
    settle();
    check(!seen_txb_any, "R2", "glitch: tx_b stayed low", int'(seen_txb_any), 0);
    check(pulses_a == 0, "R2", "glitch: echo-side pulses", pulses_a, 0);

    // high blip shorter than the filter inside a long low
    clear_mon();
    pulse_b(30);
    @(posedge clk); #1 ext_b = 1'b0;
    pulse_b(30);
    settle();
    check(pulses_a == 1, "R2", "blip: echo-side pulses", pulses_a, 1);
    check(pulses_b == 1, "R9", "blip: hold-side pulses", pulses_b, 1);

    // pulse from the echo side: holding side must not accept its own low
    clear_mon();
    pulse_a(20);
    settle();
    check(!seen_txb_any, "R5", "own low not forwarded", int'(seen_txb_any), 0);
    check(pulses_b == 1, "R10", "far pulse: hold-side pulses", pulses_b, 1);
    check(pulses_a == 1, "R9", "far pulse: echo-side pulses", pulses_a, 1);

    // overlapping pulses from both sides
    clear_mon();
    fork
      pulse_a(30);
      pulse_b(30);
    join
    settle();
    check(!tx_a && !tx_b, "R11", "overlap: links idle", int'(tx_a | tx_b), 0);
    check(!drv_a && !drv_b, "R11", "overlap: drivers idle", int'(drv_a | drv_b), 0);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule